// File: doc/BRIEF.md
# MDIO Management Frame Controller

This block is a serial management master for Clause 22 PHY access. Software hands it one 32-bit maintenance word that already holds the whole frame body: start pattern, opcode, PHY address, register address, turnaround and 16 data bits. The block sends 32 preamble ones and then the word, most significant bit first, on MDIO, timed by a management clock (MDC) that it derives from the system clock.

On a read opcode the controller stops driving the line partway through the turnaround. It then shifts in the 16 bits the PHY returns and writes them into the low half of the same word, so software fetches the result with one read. An idle flag tells software when a new word may be written. A port enable gates whether any frame goes out. A divider select chooses an MDC of the system clock divided by 32 or by 48.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: After reset `idle` is 1, `mdc` is 0, `mdio_oe` is 0 and `rd_data` is 0.
- R2: A frame is 64 MDC periods: 32 ones, then maintenance word bits 31 down to 0. For any opcode other than read (bits 29:28 not equal to 2'b10), `mdio_oe` is 1 for all 64 bits.
- R3: `mdio_o` and `mdio_oe` change only while `mdc` is low, which means on its falling edge. The value of each bit is stable across the MDC rising edge, and exactly 64 rising edges occur per frame.
- R4: With `div_sel` equal to 3 the MDC period is 48 system clocks, and with any other code it is 32. MDC is high for the second half of each period. `idle` stays 0 for exactly 64 MDC periods.
- R5: For a read (bits 29:28 = 2'b10), `mdio_oe` is 0 from frame bit 47 (word bit 16, second turnaround bit) to the end. The line is sampled on the MDC rising edges of frame bits 48..63, first bit into bit 15. At frame end `rd_data[15:0]` holds the sampled data and `rd_data[31:16]` is unchanged.
- R6: A read from an absent PHY leaves the line pulled high and returns 16'hFFFF in `rd_data[15:0]`.
- R7: A write is accepted while `idle` is 1. `idle` stays 1 in the cycle after the write and drops one cycle later when the port is enabled. It returns to 1 when the frame ends.
- R8: A write while `idle` is 0 is ignored. The word under transfer, the read result and the absence of a follow-on frame are unaffected.
- R9: With `port_en` at 0 a written word waits. `idle` stays 1, `mdc` stays 0 and `mdio_oe` stays 0. The frame starts once `port_en` is 1.
- R10: `rd_data` shows the written word as soon as the write is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| port_en | input | 1 | Management port enable |
| div_sel | input | 2 | MDC divider code: 3 gives /48, others /32 |
| wr_en | input | 1 | Maintenance word write strobe |
| wr_data | input | 32 | Maintenance word to write |
| rd_data | output | 32 | Current maintenance word, with read data after a read |
| idle | output | 1 | 1 when a new word can be accepted |
| mdc | output | 1 | Management clock |
| mdio_i | input | 1 | MDIO line input |
| mdio_o | output | 1 | MDIO output value |
| mdio_oe | output | 1 | MDIO output enable |

## Verification
The bench models a PHY that drives the line after each MDC fall and a pull-up when nobody drives. It rebuilds every frame bit at the MDC rising edges and compares it with the expected preamble and word. The release point is checked at bit 47. A controller that releases one bit late would collide with the PHY's turnaround zero, and one that releases early loses the first turnaround bit. Off-by-one capture would shift the returned data, and an absent PHY must read as all ones. Divider checks measure the period and the high time under both codes. A write injected mid-frame must leave the word intact and start no second frame. A word written with the port disabled must wait without toggling MDC.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned DATA_W   = 16;
  localparam int unsigned PRE_BITS = 32;
  localparam int unsigned FRAME_N  = PRE_BITS + WORD_W;
  localparam int unsigned BIT_W    = $clog2(FRAME_N);
  // frame index where the master lets go of the line on a read
  localparam int unsigned REL_BIT  = PRE_BITS + WORD_W - DATA_W - 1;
  localparam int unsigned CAP_BIT  = PRE_BITS + WORD_W - DATA_W;
  localparam logic [1:0]  OP_READ  = 2'b10;

  function automatic logic is_read(input logic [WORD_W-1:0] w);
    return w[29:28] == OP_READ;
  endfunction
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int unsigned DIV_LO = 32,
  parameter int unsigned DIV_HI = 48
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic run,
  input  logic sel_hi,
  output logic mdc,
  output logic rise_tick,
  output logic wrap_tick
);
  localparam int unsigned CNT_W = $clog2(DIV_HI);

  logic [CNT_W-1:0] cnt_q, cnt_d, lim_m1, half;
  logic             sel_q, sel_d, mdc_q, mdc_d;

  always_comb begin
    sel_d  = start ? sel_hi : sel_q;
    lim_m1 = sel_q ? CNT_W'(DIV_HI - 1) : CNT_W'(DIV_LO - 1);
    half   = sel_q ? CNT_W'(DIV_HI / 2) : CNT_W'(DIV_LO / 2);
    if (start || !run)       cnt_d = '0;
    else if (cnt_q == lim_m1) cnt_d = '0;
    else                      cnt_d = cnt_q + 1'b1;
    mdc_d = run && !start && (cnt_d >= half);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      sel_q <= 1'b0;
      mdc_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      sel_q <= sel_d;
      mdc_q <= mdc_d;
    end
  end

  assign mdc       = mdc_q;
  assign rise_tick = run && (cnt_q == half - 1'b1);
  assign wrap_tick = run && (cnt_q == lim_m1);

  a_r4_idle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> !mdc_q);
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [WORD_W-1:0] word,
  input  logic              rise_tick,
  input  logic              wrap_tick,
  input  logic              mdio_i,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] cap_data,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [BIT_W-1:0]  bit_q, bit_d;
  logic [DATA_W-1:0] cap_q, cap_d;
  logic              busy_q, busy_d, rd;
  logic [4:0]        pos;

  always_comb begin
    rd     = is_read(word);
    done   = busy_q && wrap_tick && (bit_q == BIT_W'(FRAME_N - 1));
    bit_d  = bit_q;
    cap_d  = cap_q;
    busy_d = busy_q;
    if (start) begin
      busy_d = 1'b1;
      bit_d  = '0;
      cap_d  = '0;
    end else if (busy_q) begin
      if (rise_tick && rd && bit_q >= BIT_W'(CAP_BIT))
        cap_d = {cap_q[DATA_W-2:0], mdio_i};
      if (done)           busy_d = 1'b0;
      else if (wrap_tick) bit_d  = bit_q + 1'b1;
    end
    pos = 5'(WORD_W - 1) - bit_q[4:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q  <= '0;
      cap_q  <= '0;
      busy_q <= 1'b0;
    end else begin
      bit_q  <= bit_d;
      cap_q  <= cap_d;
      busy_q <= busy_d;
    end
  end

  assign busy     = busy_q;
  assign cap_data = cap_d;
  assign mdio_o   = (bit_q < BIT_W'(PRE_BITS)) ? 1'b1 : word[pos];
  assign mdio_oe  = busy_q && !(rd && bit_q >= BIT_W'(REL_BIT));

  // R5: line released for the whole tail of a read frame
  a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_q && rd && bit_q > BIT_W'(REL_BIT)) |-> !mdio_oe);
  a_r2_done_once: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_q);
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl
  import mdio_pkg::*;
#(
  parameter int unsigned DIV_LO = 32,
  parameter int unsigned DIV_HI = 48
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              port_en,
  input  logic [1:0]        div_sel,
  input  logic              wr_en,
  input  logic [WORD_W-1:0] wr_data,
  output logic [WORD_W-1:0] rd_data,
  output logic              idle,
  output logic              mdc,
  input  logic              mdio_i,
  output logic              mdio_o,
  output logic              mdio_oe
);
  logic [WORD_W-1:0] word_q, word_d;
  logic              pend_q, pend_d;
  logic              busy, done, start, rise_tick, wrap_tick;
  logic [DATA_W-1:0] cap_data;

  assign start = pend_q && port_en && !busy;

  always_comb begin
    word_d = word_q;
    pend_d = pend_q;
    if (start) pend_d = 1'b0;
    if (wr_en && !busy) begin
      word_d = wr_data;
      pend_d = 1'b1;
    end else if (done && is_read(word_q)) begin
      word_d[DATA_W-1:0] = cap_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      pend_q <= 1'b0;
    end else begin
      word_q <= word_d;
      pend_q <= pend_d;
    end
  end

  mdio_clk_div #(.DIV_LO(DIV_LO), .DIV_HI(DIV_HI)) u_div (
    .clk(clk), .rst_n(rst_n), .start(start), .run(busy),
    .sel_hi(div_sel == 2'd3), .mdc(mdc),
    .rise_tick(rise_tick), .wrap_tick(wrap_tick)
  );

  mdio_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .start(start), .word(word_q),
    .rise_tick(rise_tick), .wrap_tick(wrap_tick), .mdio_i(mdio_i),
    .busy(busy), .done(done), .cap_data(cap_data),
    .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  assign rd_data = word_q;
  assign idle    = !busy;

  a_r7_fall_after_pend: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(idle) |-> $past(pend_q));
  a_r8_word_held: assert property (@(posedge clk) disable iff (!rst_n)
    !idle |=> $stable(word_q[WORD_W-1:DATA_W]));
  a_r9_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (idle && !port_en) |=> idle);
  a_r3_change_low: assert property (@(posedge clk) disable iff (!rst_n)
    (!idle && !$stable(mdio_o)) |-> !mdc);
endmodule

// File: tb/mdio_mgmt_ctrl_tb.sv
module mdio_mgmt_ctrl_tb;
  logic clk = 1'b0;
  logic rst_n, port_en, wr_en, mdio_i, phy_line;
  logic [1:0] div_sel;
  logic [31:0] wr_data, rd_data;
  logic idle, mdc, mdio_o, mdio_oe;
  int tests = 0, fails = 0;

  always #2.5 clk = ~clk;
  assign mdio_i = mdio_oe ? mdio_o : phy_line;

  mdio_mgmt_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .port_en(port_en), .div_sel(div_sel),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data), .idle(idle),
    .mdc(mdc), .mdio_i(mdio_i), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] mk_word(input bit rd, input [4:0] pa,
                                          input [4:0] ra, input [15:0] d);
    return {2'b01, rd ? 2'b10 : 2'b01, pa, ra, 2'b10, d};
  endfunction

  function automatic logic exp_bit(input [31:0] w, input int idx);
    return (idx < 32) ? 1'b1 : w[63 - idx];
  endfunction

  task automatic run_frame(input [31:0] w, input [1:0] ds, input bit present,
                           input [15:0] pd, input bit inject, input bit hold_en);
    int n, cyc, k, mism, hichg, r0, r1, f0, guard;
    bit rd, pm, po, poe, bad;
    logic [31:0] expw;
    n  = (ds == 2'd3) ? 48 : 32;
    rd = (w[29:28] == 2'b10);
    div_sel = ds;
    port_en = !hold_en;
    @(negedge clk); wr_en = 1'b1; wr_data = w;
    @(negedge clk); wr_en = 1'b0;
    chk(idle == 1'b1, "R7 idle held after write", idle, 1);
    chk(rd_data == w, "R10 readback", rd_data, w);
    if (hold_en) begin
      bad = 0;
      for (int i = 0; i < 200; i++) begin
        @(negedge clk);
        if (!idle || mdc || mdio_oe) bad = 1;
      end
      chk(!bad, "R9 held while disabled", bad, 0);
      port_en = 1'b1;
    end
    @(negedge clk);
    chk(idle == 1'b0, "R7 idle drops", idle, 0);
    cyc = 0; k = 0; mism = 0; hichg = 0; r0 = -1; r1 = -1; f0 = -1; guard = 0;
    pm = mdc; po = mdio_o; poe = mdio_oe;
    while (!idle && guard < 5000) begin
      cyc++; guard++;
      if (mdc && !pm) begin
        if (k == 0) r0 = cyc;
        if (k == 1) r1 = cyc;
        if (rd && k >= 47) begin
          if (mdio_oe) mism++;
        end else if (!mdio_oe || mdio_o != exp_bit(w, k)) mism++;
        k++;
      end
      if (!mdc && pm) begin
        if (f0 < 0) f0 = cyc;
        if (present && rd && k >= 47)
          phy_line = (k == 47) ? 1'b0 : pd[63 - k];
        else
          phy_line = 1'b1;
      end
      if (pm && mdc && (mdio_o != po || mdio_oe != poe)) hichg++;
      if (inject && cyc == 300) begin wr_en = 1'b1; wr_data = ~w; end
      if (inject && cyc == 301) wr_en = 1'b0;
      pm = mdc; po = mdio_o; poe = mdio_oe;
      @(negedge clk);
    end
    phy_line = 1'b1;
    chk(cyc == 64 * n, "R4 busy length", cyc, 64 * n);
    chk(k == 64, "R3 rising edges", k, 64);
    chk(hichg == 0, "R3 change while mdc high", hichg, 0);
    chk(r1 - r0 == n, "R4 mdc period", r1 - r0, n);
    chk(f0 - r0 == n / 2, "R4 mdc high time", f0 - r0, n / 2);
    chk(mism == 0, rd ? "R5 read frame bits" : "R2 write frame bits", mism, 0);
    expw = w;
    if (rd) expw[15:0] = present ? pd : 16'hFFFF;
    chk(rd_data == expw, rd ? (present ? "R5 read data" : "R6 absent phy") : "R2 word kept",
        rd_data, expw);
    if (inject) begin
      bad = 0;
      for (int i = 0; i < 100; i++) begin
        @(negedge clk);
        if (!idle || mdc) bad = 1;
      end
      chk(!bad && rd_data == expw, "R8 busy write ignored", rd_data, expw);
    end
  endtask

  initial begin
    int unsigned wd = 0;
    forever begin
      @(posedge clk);
      wd++;
      if (wd > 150000) begin
        tests++; fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", wd, 150000);
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
      end
    end
  end

  initial begin
    logic [31:0] w;
    void'($urandom(32'd2024));
    rst_n = 1'b0; port_en = 1'b0; div_sel = 2'd2; wr_en = 1'b0;
    wr_data = '0; phy_line = 1'b1;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(idle == 1'b1 && mdc == 1'b0 && mdio_oe == 1'b0 && rd_data == 32'h0,
        "R1 reset state", {idle, mdc, mdio_oe}, 3'b100);

    run_frame(mk_word(0, 5'd3, 5'd9, 16'hA5C3), 2'd2, 1, 16'h0, 0, 0);
    run_frame(mk_word(1, 5'd1, 5'd1, 16'h0000), 2'd3, 1, 16'h796D, 0, 0);
    run_frame(mk_word(1, 5'd31, 5'd2, 16'h1234), 2'd2, 0, 16'h0, 0, 0);
    run_frame(mk_word(0, 5'd0, 5'd31, 16'hFFFF), 2'd0, 1, 16'h0, 0, 0);
    run_frame(mk_word(1, 5'd7, 5'd4, 16'h0), 2'd3, 1, 16'h8001, 1, 0);
    run_frame(mk_word(0, 5'd5, 5'd0, 16'h0F0F), 2'd2, 1, 16'h0, 0, 1);
    for (int i = 0; i < 6; i++) begin
      w = mk_word($urandom() % 2 == 1, 5'($urandom()), 5'($urandom()), 16'($urandom()));
      run_frame(w, 2'($urandom()), ($urandom() % 4) != 0, 16'($urandom()), 0, 0);
    end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule